// File: doc/BRIEF.md
# Program Counter Sequencer with Single Return Slot

This block produces the instruction fetch address for a small 8-bit controller whose fetch and execute stages overlap. One instruction cycle lasts four clocks. The block keeps the fetch address steady for the whole cycle and updates it on the clock edge that ends the cycle. While an instruction executes, the next sequential word is already being fetched. When the executing instruction changes the flow of control, that prefetched word is thrown away. The following cycle is then marked as a dummy cycle, and the executing slot carries no instruction during it.

An instruction decoder drives one strobe for each kind of transfer: call, jump, return, a write to the low address byte, and a conditional skip. It also drives a target address, the byte written to the low address register and the result of the skip test. The block samples these strobes in the last phase of each cycle. The return slot holds one address only. A nested call overwrites it with no warning. A write to the low byte moves the address only within the current 256-word page.

Top module: `pc_seq`

## Requirements
- R1: While reset is low, and in the first instruction cycle after reset, `fetch_addr` is 000h and `phase` is 0. `dummy_cyc` is high in that first cycle.
- R2: An instruction cycle lasts four clocks, with `phase` counting 0 to 3. `cyc_end` is high exactly when `phase` is 3. `fetch_addr` and `dummy_cyc` change only on the clock edge that ends a cycle, and the strobes are sampled only at that edge.
- R3: When no transfer is taken, the next `fetch_addr` is the current one plus one, modulo 1024, so 3FFh is followed by 000h.
- R4: A jump (`jmp_req`) makes the next `fetch_addr` equal to `target`.
- R5: A call (`call_req`) makes the next `fetch_addr` equal to `target`. It also stores the current `fetch_addr`, which is the word after the call, in the return slot.
- R6: A return (`ret_req`) makes the next `fetch_addr` equal to the return slot. The slot holds 000h after reset, so a return with no earlier call goes to 000h.
- R7: The return slot has one entry. A second call replaces the stored address, and a later return uses the address from the most recent call.
- R8: A write to the low byte (`pcl_wr`) sets the next `fetch_addr` to bits 9:8 of the current `fetch_addr` followed by `pcl_data` in bits 7:0.
- R9: A skip (`skip_req`) with `skip_met` high advances `fetch_addr` by one and marks the next cycle as a dummy. A skip with `skip_met` low behaves like no transfer and adds no dummy cycle.
- R10: After each taken transfer or taken skip, `dummy_cyc` is high for exactly one instruction cycle. Strobes sampled at the end of a dummy cycle have no effect: the address advances by one, the return slot is left unchanged, and the next cycle is not a dummy.
- R11: When several strobes are high together, only the highest in this order takes effect: call, jump, return, low-byte write, skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_req | input | 1 | Executing instruction is a subroutine call |
| jmp_req | input | 1 | Executing instruction is an unconditional jump |
| ret_req | input | 1 | Executing instruction is a return |
| pcl_wr | input | 1 | Executing instruction writes the low address byte |
| pcl_data | input | 8 | Value written to the low address byte |
| skip_req | input | 1 | Executing instruction is a conditional skip |
| skip_met | input | 1 | The skip condition is true |
| target | input | 10 | Destination address for a jump or call |
| fetch_addr | output | 10 | Address of the word fetched in this cycle |
| dummy_cyc | output | 1 | The executing slot of this cycle holds a discarded instruction |
| cyc_end | output | 1 | Last clock of the instruction cycle; strobes are sampled here |
| phase | output | 2 | Clock index within the instruction cycle |

## Verification
The hardest situation to reach from the ports is a transfer request that arrives during a dummy cycle. The ports give no view of the return slot, so a call ignored during a dummy cycle only shows up through a later return. The stimulus therefore follows every taken transfer with strobes in the dummy cycle, including a call with a fresh target, and then issues a return to confirm that the slot kept its earlier value. Random cycles draw the strobes sparsely and often together, which exercises the priority order. Directed sequences cover the wrap from 3FFh, a return straight after reset, and two calls in a row.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  typedef enum logic [1:0] {
    NXT_INC  = 2'd0,
    NXT_TGT  = 2'd1,
    NXT_STK  = 2'd2,
    NXT_PAGE = 2'd3
  } nxt_sel_e;

  typedef struct packed {
    logic call;
    logic jmp;
    logic ret;
    logic pcl;
    logic skip;
  } req_t;
endpackage

// File: rtl/pc_seq_phase.sv
module pc_seq_phase #(
  parameter int PHASES = 4,
  localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_W-1:0] phase,
  output logic            cyc_end
);
  localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

  assign cyc_end = (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (cyc_end) phase <= '0;
    else              phase <= phase + 1'b1;
  end
endmodule

// File: rtl/pc_seq_arb.sv
module pc_seq_arb
  import pc_seq_pkg::*;
(
  input  req_t     req,
  input  logic     skip_met,
  input  logic     in_dummy,
  output nxt_sel_e sel,
  output logic     push,
  output logic     redirect,
  output logic     skip_taken
);
  always_comb begin
    sel        = NXT_INC;
    push       = 1'b0;
    redirect   = 1'b0;
    skip_taken = 1'b0;
    if (!in_dummy) begin
      if (req.call) begin
        sel = NXT_TGT; push = 1'b1; redirect = 1'b1;
      end else if (req.jmp) begin
        sel = NXT_TGT; redirect = 1'b1;
      end else if (req.ret) begin
        sel = NXT_STK; redirect = 1'b1;
      end else if (req.pcl) begin
        sel = NXT_PAGE; redirect = 1'b1;
      end else if (req.skip && skip_met) begin
        skip_taken = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pc_seq_slot.sv
module pc_seq_slot #(
  parameter int PC_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_addr,
  output logic [PC_W-1:0] rd_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_addr <= '0;
    else if (wr_en) rd_addr <= wr_addr;
  end
endmodule

// File: rtl/pc_seq.sv
module pc_seq
  import pc_seq_pkg::*;
#(
  parameter int PC_W   = 10,
  parameter int PAGE_W = 8,
  parameter int PHASES = 4,
  localparam int PH_W  = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_req,
  input  logic              jmp_req,
  input  logic              ret_req,
  input  logic              pcl_wr,
  input  logic [PAGE_W-1:0] pcl_data,
  input  logic              skip_req,
  input  logic              skip_met,
  input  logic [PC_W-1:0]   target,
  output logic [PC_W-1:0]   fetch_addr,
  output logic              dummy_cyc,
  output logic              cyc_end,
  output logic [PH_W-1:0]   phase
);
  localparam logic [PC_W-1:0] LOW_MASK = PC_W'((64'd1 << PAGE_W) - 64'd1);

  function automatic logic [PC_W-1:0] page_merge(input logic [PC_W-1:0] cur,
                                                 input logic [PAGE_W-1:0] low);
    return (cur & ~LOW_MASK) | (PC_W'(low) & LOW_MASK);
  endfunction

  function automatic logic [PC_W-1:0] pick_next(input nxt_sel_e s,
                                                input logic [PC_W-1:0] cur,
                                                input logic [PC_W-1:0] tgt,
                                                input logic [PC_W-1:0] slot,
                                                input logic [PAGE_W-1:0] low);
    case (s)
      NXT_TGT:  return tgt;
      NXT_STK:  return slot;
      NXT_PAGE: return page_merge(cur, low);
      default:  return cur + 1'b1;
    endcase
  endfunction

  req_t            req;
  nxt_sel_e        sel;
  logic            push_evt;
  logic            redirect_evt;
  logic            skip_evt;
  logic            flush_evt;
  logic            ret_evt;
  logic            page_evt;
  logic [PC_W-1:0] ret_addr;
  logic [PC_W-1:0] nxt_addr;

  assign req = '{call: call_req, jmp: jmp_req, ret: ret_req, pcl: pcl_wr, skip: skip_req};

  pc_seq_phase #(.PHASES(PHASES)) u_phase (
    .clk(clk), .rst_n(rst_n), .phase(phase), .cyc_end(cyc_end)
  );

  pc_seq_arb u_arb (
    .req(req), .skip_met(skip_met), .in_dummy(dummy_cyc),
    .sel(sel), .push(push_evt), .redirect(redirect_evt), .skip_taken(skip_evt)
  );

  pc_seq_slot #(.PC_W(PC_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .wr_en(cyc_end && push_evt),
    .wr_addr(fetch_addr), .rd_addr(ret_addr)
  );

  assign flush_evt = redirect_evt | skip_evt;
  assign ret_evt   = (sel == NXT_STK);
  assign page_evt  = (sel == NXT_PAGE);
  assign nxt_addr  = pick_next(sel, fetch_addr, target, ret_addr, pcl_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_addr <= '0;
      dummy_cyc  <= 1'b1;
    end else if (cyc_end) begin
      fetch_addr <= nxt_addr;
      dummy_cyc  <= flush_evt;
    end
  end
endmodule

// File: rtl/pc_seq_chk.sv
module pc_seq_chk #(
  parameter int PC_W   = 10,
  parameter int PAGE_W = 8,
  parameter int PH_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_end,
  input logic [PH_W-1:0]   phase,
  input logic [PC_W-1:0]   fetch_addr,
  input logic              dummy_cyc,
  input logic [PC_W-1:0]   target,
  input logic [PAGE_W-1:0] pcl_data,
  input logic [PC_W-1:0]   ret_addr,
  input logic              push_evt,
  input logic              redirect_evt,
  input logic              flush_evt,
  input logic              ret_evt,
  input logic              page_evt
);
  localparam logic [PC_W-1:0] LOW_MASK = PC_W'((64'd1 << PAGE_W) - 64'd1);

  a_r2_hold_mid_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_end |=> $stable(fetch_addr) && $stable(dummy_cyc));

  a_r2_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> phase == '0);

  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end && !redirect_evt |=> fetch_addr == PC_W'($past(fetch_addr) + 1'b1));

  a_r5_call_saves: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end && push_evt |=> fetch_addr == $past(target) && ret_addr == $past(fetch_addr));

  a_r6_return: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end && ret_evt |=> fetch_addr == $past(ret_addr));

  a_r8_same_page: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end && page_evt |=>
      (fetch_addr & ~LOW_MASK) == ($past(fetch_addr) & ~LOW_MASK) &&
      (fetch_addr & LOW_MASK) == PC_W'($past(pcl_data)));

  a_r10_flush_marks: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end && flush_evt |=> dummy_cyc);

  a_r10_dummy_once: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end && dummy_cyc |=> !dummy_cyc && $stable(ret_addr));
endmodule

bind pc_seq pc_seq_chk #(.PC_W(PC_W), .PAGE_W(PAGE_W), .PH_W(PH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_end(cyc_end), .phase(phase),
  .fetch_addr(fetch_addr), .dummy_cyc(dummy_cyc), .target(target),
  .pcl_data(pcl_data), .ret_addr(ret_addr), .push_evt(push_evt),
  .redirect_evt(redirect_evt), .flush_evt(flush_evt), .ret_evt(ret_evt),
  .page_evt(page_evt)
);

// File: tb/pc_seq_bench.sv
`timescale 1ns/1ps
module pc_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       call_req = 0, jmp_req = 0, ret_req = 0, pcl_wr = 0;
  logic [7:0] pcl_data = 0;
  logic       skip_req = 0, skip_met = 0;
  logic [9:0] target = 0;
  logic [9:0] fetch_addr;
  logic       dummy_cyc, cyc_end;
  logic [1:0] phase;

  int    nchk = 0, nerr = 0;
  int    m_pc = 0, m_slot = 0;
  logic  m_dummy = 1'b1;
  string m_tag = "R1";
  bit    done = 0;

  always #2.5 clk = ~clk;

  pc_seq u_pc_seq (
    .clk(clk), .rst_n(rst_n), .call_req(call_req), .jmp_req(jmp_req),
    .ret_req(ret_req), .pcl_wr(pcl_wr), .pcl_data(pcl_data),
    .skip_req(skip_req), .skip_met(skip_met), .target(target),
    .fetch_addr(fetch_addr), .dummy_cyc(dummy_cyc), .cyc_end(cyc_end),
    .phase(phase)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int page_of(input int a, input int low);
    return (a / 256) * 256 + low;
  endfunction

  // Called at a falling edge in phase 0; returns at the falling edge of the next phase 0.
  task automatic do_cycle(input logic c, input logic j, input logic r, input logic p,
                          input int pd, input logic s, input logic sm, input int tg,
                          input string ovr);
    int    nxt;
    logic  fl;
    string t;
    int    held;
    chk(m_tag, fetch_addr, m_pc);
    chk(m_tag, dummy_cyc, m_dummy);
    chk("R2", phase, 0);
    call_req = c; jmp_req = j; ret_req = r; pcl_wr = p;
    pcl_data = 8'(pd); skip_req = s; skip_met = sm; target = 10'(tg);
    fl = 1'b0;
    nxt = (m_pc + 1) % 1024;
    if (m_dummy) begin
      t = (c | j | r | p | s) ? "R10" : "R3";
    end else begin
      if (c) begin m_slot = m_pc; nxt = tg; fl = 1; t = "R5"; end
      else if (j) begin nxt = tg; fl = 1; t = "R4"; end
      else if (r) begin nxt = m_slot; fl = 1; t = "R6"; end
      else if (p) begin nxt = page_of(m_pc, pd); fl = 1; t = "R8"; end
      else if (s) begin fl = sm; t = "R9"; end
      else t = "R3";
      if (int'(c) + int'(j) + int'(r) + int'(p) + int'(s) > 1) t = "R11";
    end
    if (ovr != "") t = ovr;
    held = m_pc;
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      chk("R2", fetch_addr, held);
      chk("R2", cyc_end, (k == 3) ? 1 : 0);
    end
    @(negedge clk);
    m_pc = nxt; m_dummy = fl; m_tag = t;
  endtask

  task automatic nop(input string ovr);
    do_cycle(0, 0, 0, 0, 0, 0, 0, 0, ovr);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", fetch_addr, 0);
    chk("R1", dummy_cyc, 1);
    chk("R1", phase, 0);
    rst_n = 1'b1;
    // first cycle is a dummy: a call here must be ignored (R10, R1)
    do_cycle(1, 0, 0, 0, 0, 0, 0, 10'h155, "R1");
    // return with nothing pushed goes to 000h (R6)
    do_cycle(0, 0, 1, 0, 0, 0, 0, 0, "R6");
    nop("R10");
    // wrap from 3FFh (R3)
    do_cycle(0, 1, 0, 0, 0, 0, 0, 10'h3FE, "R4");
    nop("R10");
    nop("R3");
    nop("R3");
    // two calls in a row with a call in between dummy (R7)
    do_cycle(1, 0, 0, 0, 0, 0, 0, 10'h120, "R5");
    do_cycle(1, 0, 0, 0, 0, 0, 0, 10'h2AA, "R10");
    do_cycle(1, 0, 0, 0, 0, 0, 0, 10'h240, "R7");
    nop("R10");
    do_cycle(0, 0, 1, 0, 0, 0, 0, 0, "R7");
    nop("R10");
    // low-byte write at the page edge (R8)
    do_cycle(0, 1, 0, 0, 0, 0, 0, 10'h2FF, "R4");
    nop("R10");
    do_cycle(0, 0, 0, 1, 8'h10, 0, 0, 0, "R8");
    nop("R10");
    // skip met and not met (R9)
    do_cycle(0, 0, 0, 0, 0, 1, 0, 0, "R9");
    do_cycle(0, 0, 0, 0, 0, 1, 1, 0, "R9");
    nop("R10");
    // all strobes together (R11)
    do_cycle(1, 1, 1, 1, 8'h77, 1, 1, 10'h0C3, "R11");
    do_cycle(0, 1, 1, 1, 8'h77, 1, 1, 10'h0C3, "R10");
    do_cycle(0, 0, 1, 1, 8'h77, 1, 1, 10'h0C3, "R11");
    do_cycle(0, 0, 0, 1, 8'h33, 1, 1, 10'h000, "R10");
    do_cycle(0, 0, 0, 1, 8'h33, 1, 1, 10'h000, "R11");
    nop("R10");
    for (int i = 0; i < 800; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      do_cycle(rv[2:0] == 0, rv[5:3] == 0, rv[8:6] == 0, rv[11:9] == 0,
               int'(rv[19:12]), rv[21:20] == 0, rv[22], int'(rv[31:22]), "");
    end
    nop("");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL R2: watchdog actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule